// File: doc/BRIEF.md
# BCD Watchdog Alarm Counter

This block is a watchdog timer whose count is held as packed BCD digits, two digits per byte, so software sees the remaining time directly in decimal. With the default four digits it spans 0.01 s to 99.99 s in 10 ms steps. A one-cycle `tick` input, pulsed once every 10 ms by a prescaler elsewhere on the chip, drives the count down. Software reaches the count through a byte-wide register port, with one byte address per pair of digits. Address 0 holds the two least significant digits.

Every byte write updates the matching byte of a seed register. The whole live count is then reloaded from the seed. A read of byte 0 returns the low byte, freezes the full count into a snapshot so that the higher bytes read back coherently, and reloads the live count. A read of a higher byte returns the snapshot byte and also reloads the live count. So any register access restarts the timer.

When the timer counts down to zero it sets a sticky flag. If the reset-select input is set, it also asserts `rst_req` for a fixed number of cycles. While `rst_req` is high, register and flag accesses are refused. With the enable input low, the bytes are plain storage.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset, `rd_data`, `wd_flag` and `rst_req` are 0, and the count, seed and snapshot all read as 0.
- R2: A write to byte address k replaces byte k of the seed, and the live count reloads with the whole updated seed. The write takes priority over a tick in the same cycle.
- R3: While `wd_enable` is 1 and the count is non-zero, each `tick` lowers the count by one in BCD, with a borrow per nibble (0x0100 becomes 0x0099 and 0x1000 becomes 0x0999). The count stays at 0x0000 and never wraps.
- R4: When a tick takes the count from 0x0001 to 0x0000, `wd_flag` is 1 from the next cycle on.
- R5: If `rst_select` is 1 in that expiry cycle, `rst_req` goes high in the next cycle and stays high for exactly RST_CYCLES cycles. If `rst_select` is 0, `rst_req` stays low.
- R6: A read of byte 0 presents the count's low byte on `rd_data` in the next cycle and captures the full count into the snapshot. A read of byte k>0 presents snapshot byte k. Both kinds of read reload the live count from the seed.
- R7: Writing every count byte to 0x00 while enabled stops the timer. Ticks then leave it at 0, and `wd_flag` is not set.
- R8: With `wd_enable` at 0, ticks never change the count and never set `wd_flag`. The bytes read back exactly as written.
- R9: `wd_flag` stays set until `flag_wr` is pulsed with `flag_wdata` = 0. A pulse with `flag_wdata` = 1 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R10: While `rst_req` is high, count writes and flag writes are ignored, and a read returns 0x00 on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle count byte write strobe |
| rd_en | input | 1 | One-cycle count byte read strobe |
| addr | input | ADDR_W | Byte address, 0 = least significant digits |
| wr_data | input | 8 | Write data, two packed BCD digits |
| tick | input | 1 | 10 ms count enable, one cycle wide |
| wd_enable | input | 1 | 1 = watchdog counts, 0 = plain storage |
| rst_select | input | 1 | 1 = request a reset pulse on expiry |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write value (only 0 has an effect) |
| rd_data | output | 8 | Registered read data, valid the cycle after a read |
| wd_flag | output | 1 | Sticky expiry flag |
| rst_req | output | 1 | Reset request pulse, RST_CYCLES long |

## Verification
The decrement is driven from seeds that need no borrow, one borrow (0x0100) and a two-nibble borrow (0x1000). These cases tell a proper BCD borrow apart from binary subtraction and from a single-digit borrow. Expiry is run with reset-select both clear and set, which separates setting the flag from starting the pulse. The pulse length is counted cycle by cycle, and writes, reads and flag clears are issued inside the pulse to show that they are refused. An all-zero write, a disabled timer, a read followed by a tick (which shows the reload) and a clear that collides with an expiry cover the remaining orderings.

// File: rtl/bcd_wd_pkg.sv
package bcd_wd_pkg;
    parameter int unsigned WD_DIGITS   = 4;
    parameter int unsigned DIGIT_W     = 4;
    parameter int unsigned BYTE_W      = 8;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    function automatic bcd_digit_t digit_dec(input bcd_digit_t d, input logic borrow_in);
        bcd_digit_t r;
        if (!borrow_in)
            r = d;
        else if (d == '0)
            r = bcd_digit_t'(9);
        else
            r = d - bcd_digit_t'(1);
        return r;
    endfunction
endpackage

// File: rtl/bcd_wd_decrement.sv
module bcd_wd_decrement
    import bcd_wd_pkg::*;
#(
    parameter int unsigned DIGITS = WD_DIGITS,
    localparam int unsigned CW    = DIGITS * DIGIT_W
) (
    input  logic [CW-1:0] value_i,
    output logic [CW-1:0] value_o,
    output logic          zero_o
);
    logic [DIGITS:0] borrow;

    assign borrow[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_t din;
        assign din                          = value_i[g*DIGIT_W +: DIGIT_W];
        assign value_o[g*DIGIT_W +: DIGIT_W] = digit_dec(din, borrow[g]);
        assign borrow[g+1]                  = borrow[g] && (din == '0);
    end

    assign zero_o = (value_o == '0);
endmodule

// File: rtl/bcd_wd_pulse.sv
module bcd_wd_pulse #(
    parameter int unsigned CYCLES = 2000,
    localparam int unsigned PW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    logic [PW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (start_i)
            left_d = PW'(CYCLES);
        else if (left_q != '0)
            left_d = left_q - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else
            left_q <= left_d;
    end

    assign active_o = (left_q != '0);
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
    import bcd_wd_pkg::*;
#(
    parameter int unsigned DIGITS     = WD_DIGITS,
    parameter int unsigned RST_CYCLES = 2000,
    localparam int unsigned CW        = DIGITS * DIGIT_W,
    localparam int unsigned NBYTES    = CW / BYTE_W,
    localparam int unsigned ADDR_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              tick,
    input  logic              wd_enable,
    input  logic              rst_select,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [7:0]        rd_data,
    output logic              wd_flag,
    output logic              rst_req
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] seed;
        logic [CW-1:0] snap;
        logic [7:0]    rd;
        logic          flag;
    } wd_state_t;

    wd_state_t state_d, state_q;

    logic [CW-1:0] dec_value;
    logic          dec_zero;
    logic          blocked;
    logic          expire;
    logic [CW-1:0] cnt_now;

    bcd_wd_decrement #(.DIGITS(DIGITS)) u_dec (
        .value_i (state_q.cnt),
        .value_o (dec_value),
        .zero_o  (dec_zero)
    );

    bcd_wd_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (expire && rst_select),
        .active_o (blocked)
    );

    always_comb begin
        logic wr_ok;
        logic rd_ok;
        logic addr_ok;
        logic counting;

        state_d  = state_q;
        addr_ok  = (int'(addr) < NBYTES);
        wr_ok    = wr_en && !blocked && addr_ok;
        rd_ok    = rd_en && !blocked && addr_ok;
        counting = wd_enable && tick && (state_q.cnt != '0);
        expire   = counting && !wr_ok && !rd_ok && dec_zero;

        if (wr_ok)
            state_d.seed[int'(addr)*BYTE_W +: BYTE_W] = wr_data;

        if (wr_ok || rd_ok)
            state_d.cnt = state_d.seed;
        else if (counting)
            state_d.cnt = dec_value;

        if (rd_en && blocked) begin
            state_d.rd = '0;
        end else if (rd_ok) begin
            if (addr == '0) begin
                state_d.rd   = state_q.cnt[BYTE_W-1:0];
                state_d.snap = state_q.cnt;
            end else begin
                state_d.rd = state_q.snap[int'(addr)*BYTE_W +: BYTE_W];
            end
        end

        if (expire)
            state_d.flag = 1'b1;
        else if (flag_wr && !flag_wdata && !blocked)
            state_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign cnt_now = state_q.cnt;
    assign rd_data = state_q.rd;
    assign wd_flag = state_q.flag;
    assign rst_req = blocked;
endmodule

// File: rtl/bcd_watchdog_chk.sv
module bcd_watchdog_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          tick,
    input logic          wd_enable,
    input logic          rst_select,
    input logic          flag_wr,
    input logic          flag_wdata,
    input logic [7:0]    rd_data,
    input logic          wd_flag,
    input logic          rst_req,
    input logic [CW-1:0] cnt_now
);
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !(flag_wr && !flag_wdata)) |=> wd_flag);

    a_r4_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(tick && wd_enable));

    a_r5_pulse_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(rst_select) && wd_flag));

    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_enable && !wr_en && !rd_en) |=> $stable(cnt_now));

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_now == '0) && !wr_en && !rd_en) |=> (cnt_now == '0));

    a_r10_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rst_req) |=> (rd_data == 8'h00));
endmodule

bind bcd_watchdog bcd_watchdog_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .tick       (tick),
    .wd_enable  (wd_enable),
    .rst_select (rst_select),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .rd_data    (rd_data),
    .wd_flag    (wd_flag),
    .rst_req    (rst_req),
    .cnt_now    (cnt_now)
);

// File: tb/sim_bcd_watchdog.sv
`timescale 1ns/1ps
module sim_bcd_watchdog;
    localparam int RSTC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [0:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0, wd_enable = 1'b0, rst_select = 1'b0;
    logic       flag_wr = 1'b0, flag_wdata = 1'b0;
    logic [7:0] rd_data;
    logic       wd_flag, rst_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bcd_watchdog #(.DIGITS(4), .RST_CYCLES(RSTC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .tick(tick), .wd_enable(wd_enable),
        .rst_select(rst_select), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .rd_data(rd_data), .wd_flag(wd_flag), .rst_req(rst_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_byte(input logic a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic flag_write(input logic v);
        @(negedge clk); flag_wr = 1'b1; flag_wdata = v;
        @(negedge clk); flag_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 rd_data", rd_data, 0);
        check("R1 flag", wd_flag, 0);
        check("R1 rst_req", rst_req, 0);
        rd_byte(1'b0, d); check("R1 low byte", d, 0);
        rd_byte(1'b1, d); check("R1 high byte", d, 0);
    endtask

    task automatic t_storage;
        logic [7:0] d;
        wd_enable = 1'b0;
        wr_byte(1'b0, 8'h34);
        wr_byte(1'b1, 8'h12);
        ticks(5);
        check("R8 flag", wd_flag, 0);
        rd_byte(1'b0, d); check("R8 low", d, 8'h34);
        rd_byte(1'b1, d); check("R8 high", d, 8'h12);
    endtask

    task automatic t_write_reload;
        logic [7:0] d;
        wd_enable = 1'b1;
        wr_byte(1'b0, 8'h42);
        wr_byte(1'b1, 8'h00);
        ticks(2);
        rd_byte(1'b0, d); check("R3 plain dec", d, 8'h40);
        ticks(3);
        wr_byte(1'b1, 8'h00);
        rd_byte(1'b0, d); check("R2 write reloads seed", d, 8'h42);
        wd_enable = 1'b0;
    endtask

    task automatic t_borrow;
        logic [7:0] d;
        wd_enable = 1'b1;
        wr_byte(1'b0, 8'h00);
        wr_byte(1'b1, 8'h01);
        ticks(1);
        rd_byte(1'b0, d); check("R3 borrow 0100 low", d, 8'h99);
        rd_byte(1'b1, d); check("R6 snapshot high 0099", d, 8'h00);
        wr_byte(1'b1, 8'h10);
        ticks(1);
        rd_byte(1'b0, d); check("R3 borrow 1000 low", d, 8'h99);
        ticks(1);
        rd_byte(1'b1, d); check("R6 snapshot held high", d, 8'h09);
        ticks(1);
        rd_byte(1'b0, d); check("R6 read reloaded seed", d, 8'h99);
        rd_byte(1'b1, d); check("R6 high after reload", d, 8'h09);
        wd_enable = 1'b0;
    endtask

    task automatic t_expire_no_rst;
        logic [7:0] d;
        wd_enable = 1'b1; rst_select = 1'b0;
        wr_byte(1'b0, 8'h03);
        wr_byte(1'b1, 8'h00);
        ticks(2);
        check("R4 no flag before zero", wd_flag, 0);
        ticks(1);
        check("R4 flag at zero", wd_flag, 1);
        check("R5 no pulse when not selected", rst_req, 0);
        ticks(3);
        rd_byte(1'b0, d); check("R3 stays at zero", d, 8'h00);
        wd_enable = 1'b0;
        flag_write(1'b1);
        check("R9 write one no effect", wd_flag, 1);
        flag_write(1'b0);
        check("R9 write zero clears", wd_flag, 0);
    endtask

    task automatic t_zero_disarm;
        logic [7:0] d;
        wd_enable = 1'b1;
        wr_byte(1'b0, 8'h00);
        wr_byte(1'b1, 8'h00);
        ticks(3);
        check("R7 no flag", wd_flag, 0);
        rd_byte(1'b0, d); check("R7 count zero", d, 8'h00);
        wd_enable = 1'b0;
    endtask

    task automatic t_pulse;
        logic [7:0] d;
        int n;
        wd_enable = 1'b1; rst_select = 1'b1;
        wr_byte(1'b0, 8'h01);
        wr_byte(1'b1, 8'h00);
        ticks(1);
        n = 0;
        while (rst_req && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R5 pulse length", n, RSTC);
        check("R5 flag set", wd_flag, 1);
        wr_byte(1'b0, 8'h01);
        ticks(1);
        check("R5 pulse again", rst_req, 1);
        wr_byte(1'b0, 8'h55);
        flag_write(1'b0);
        rd_byte(1'b0, d); check("R10 blocked read zero", d, 8'h00);
        check("R10 still blocked", rst_req, 1);
        n = 0;
        while (rst_req && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R10 flag clear ignored", wd_flag, 1);
        rd_byte(1'b0, d); check("R10 write ignored", d, 8'h00);
        rst_select = 1'b0;
        flag_write(1'b0);
        wd_enable = 1'b0;
    endtask

    task automatic t_set_wins;
        wd_enable = 1'b1;
        wr_byte(1'b0, 8'h01);
        wr_byte(1'b1, 8'h00);
        @(negedge clk); tick = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
        @(negedge clk); tick = 1'b0; flag_wr = 1'b0;
        check("R9 expiry beats clear", wd_flag, 1);
        flag_write(1'b0);
        check("R9 cleared after", wd_flag, 0);
        wd_enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_storage();
        t_write_reload();
        t_borrow();
        t_expire_no_rst();
        t_zero_disarm();
        t_pulse();
        t_set_wins();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog timeout: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule